// File: doc/BRIEF.md
# Interrupt Vector Priority Resolver

This block keeps the interrupt bookkeeping for one processor core across 256 vectors. Three 256-bit state sets are held: a pending set for requests waiting to be taken, an in-service set for vectors the core has accepted and not yet retired, and a level set that records whether each pending request was level-triggered. The block derives a processor priority from a programmable task priority and from the highest vector in service. It then offers the core the highest pending vector whose priority class beats that processor priority.

Requests arrive on an accept port that carries a vector and a level flag. The core takes the offered vector with an acknowledge strobe and later retires the most urgent in-service vector with an end-of-interrupt (EOI) strobe. The block then broadcasts the retired vector and its trigger kind to the interrupt routers downstream. Software sets the task priority through a write port. The 256-bit searches are purely combinational, and every output is registered.

Top module: `vec_prio_resolver`

## Requirements
- R1: A synchronous active-high reset clears the pending, in-service and level sets and the task priority. In the cycle after reset, `dlv_valid` is 0, `ppr_out` is 0x00 and `eoi_valid` is 0.
- R2: An accept with `acc_valid`=1 sets the pending bit of `acc_vec` and records `acc_level` (1 = level, 0 = edge) as that vector's trigger kind. If the vector's pending bit is already set, the request is dropped and its level flag is not recorded.
- R3: When `dlv_valid` is 1, `dlv_vec` is the numerically highest pending vector.
- R4: The processor priority is computed from the task priority T and from S, where S is the highest in-service vector, or 0 when nothing is in service. It equals T when T[7:4] >= S[7:4], and {S[7:4],4'h0} otherwise. `ppr_out` presents it.
- R5: The highest pending vector is offered (`dlv_valid`=1) only when `glb_en` is 1 and {vector[7:4],4'h0} is strictly greater than the processor priority. A vector in class 0 (0x00 to 0x0F) is therefore never offered.
- R6: An `ack` sampled while `dlv_valid` is 1 and `glb_en` is 1 moves `dlv_vec` from the pending set into the in-service set. An `ack` in any other cycle has no effect.
- R7: An `eoi_wr` clears the highest in-service vector and its level flag. In the next cycle, `eoi_valid` pulses for one cycle with `eoi_vec` set to that vector and `eoi_level` set to its recorded trigger kind. `eoi_level` is 0 whenever `eoi_valid` is 0.
- R8: An `eoi_wr` while nothing is in service produces no pulse and leaves all state unchanged.
- R9: A task-priority write (`tpr_wr`) keeps only `tpr_data[7:0]`. Bits 31:8 are ignored.
- R10: Outputs are registered from the state as it stood before the clock edge. Any strobe (`acc_valid`, `ack`, `eoi_wr`, `tpr_wr`) forces `dlv_valid` to 0 in the following cycle, and the offer reflects the new state one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable for delivery |
| acc_valid | input | 1 | Accept a request this cycle |
| acc_vec | input | 8 | Requested vector |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge |
| ack | input | 1 | Core takes the offered vector |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_data | input | 32 | Task-priority write data (low byte used) |
| dlv_valid | output | 1 | A vector is offered |
| dlv_vec | output | 8 | Offered vector |
| ppr_out | output | 8 | Processor priority |
| eoi_valid | output | 1 | EOI broadcast pulse |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level-triggered |

## Verification
The assertions assume that strobes are sampled only at clock edges and are never unknown. They also assume that `glb_en` stays stable within a cycle, so the quiet cycle after a strobe and the enable gate can be checked against registered history. The stimulus drives every input on the falling edge and holds it for the whole cycle. It mixes random accepts, acknowledges, EOIs, task-priority writes and rare enable drops with directed sequences for duplicate requests, strict class comparison, nested service and an empty EOI.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  localparam int VEC_W_DEF  = 8;
  localparam int WORD_W_DEF = 32;
  localparam int BUS_W_DEF  = 32;
  localparam int CLS_W      = 4;

  typedef logic [VEC_W_DEF-1:0] vec_t;

  typedef struct packed {
    logic valid;
    vec_t vec;
    logic level;
  } eoi_evt_t;
endpackage

// File: rtl/vpr_find_top.sv
module vpr_find_top #(
  parameter int WIDTH  = 256,
  parameter int WORD_W = 32,
  localparam int NW    = WIDTH / WORD_W,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int SEL_W = $clog2(NW),
  localparam int IDX_W = SEL_W + BIT_W
) (
  input  logic [WIDTH-1:0] bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [NW-1:0]       w_any;
  logic [NW*BIT_W-1:0] w_idx;

  // one leading-one finder per word
  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [BIT_W-1:0] b_idx;
    always_comb begin
      b_idx = '0;
      for (int i = 0; i < WORD_W; i++)
        if (bits[g*WORD_W + i]) b_idx = BIT_W'(i);
    end
    assign w_any[g] = |bits[g*WORD_W +: WORD_W];
    assign w_idx[g*BIT_W +: BIT_W] = b_idx;
  end

  // pick the highest non-empty word
  logic [SEL_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int w = 0; w < NW; w++)
      if (w_any[w]) sel = SEL_W'(w);
  end

  assign found = |w_any;
  assign idx   = {sel, w_idx[sel*BIT_W +: BIT_W]};
endmodule

// File: rtl/vpr_ppr.sv
module vpr_ppr #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4,
  localparam int LSB  = VEC_W - CLS_W
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic             svc_found,
  input  logic [VEC_W-1:0] svc_top,
  output logic [VEC_W-1:0] ppr
);
  logic [VEC_W-1:0] svc_eff;
  assign svc_eff = svc_found ? svc_top : '0;

  always_comb begin
    if (tpr[VEC_W-1:LSB] >= svc_eff[VEC_W-1:LSB]) ppr = tpr;
    else ppr = {svc_eff[VEC_W-1:LSB], {LSB{1'b0}}};
  end
endmodule

// File: rtl/vpr_vec_state.sv
module vpr_vec_state #(
  parameter int VEC_W = 8,
  localparam int NVEC = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [VEC_W-1:0] acc_vec,
  input  logic             acc_level,
  input  logic             ack_fire,
  input  logic [VEC_W-1:0] ack_vec,
  input  logic             eoi_fire,
  input  logic [VEC_W-1:0] eoi_vec,
  output logic [NVEC-1:0]  pend,
  output logic [NVEC-1:0]  svc,
  output logic [NVEC-1:0]  lvl
);
  logic [NVEC-1:0] acc_bit, ack_mask, eoi_mask;
  logic            acc_take;
  logic [NVEC-1:0] pend_n, svc_n, lvl_n;

  assign acc_bit  = NVEC'(1) << acc_vec;
  assign ack_mask = ack_fire ? (NVEC'(1) << ack_vec) : '0;
  assign eoi_mask = eoi_fire ? (NVEC'(1) << eoi_vec) : '0;
  // duplicate test looks at the pending set before this edge
  assign acc_take = acc_valid && !pend[acc_vec];

  always_comb begin
    pend_n = (pend & ~ack_mask) | (acc_take ? acc_bit : '0);
    svc_n  = (svc & ~eoi_mask) | ack_mask;
    lvl_n  = lvl & ~eoi_mask;
    if (acc_take) lvl_n[acc_vec] = acc_level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      svc  <= '0;
      lvl  <= '0;
    end else begin
      pend <= pend_n;
      svc  <= svc_n;
      lvl  <= lvl_n;
    end
  end
endmodule

// File: rtl/vec_prio_resolver.sv
module vec_prio_resolver
  import vpr_pkg::*;
#(
  parameter int VEC_W  = VEC_W_DEF,
  parameter int WORD_W = WORD_W_DEF,
  parameter int BUS_W  = BUS_W_DEF,
  localparam int NVEC  = 1 << VEC_W,
  localparam int LSB   = VEC_W - CLS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glb_en,
  input  logic             acc_valid,
  input  logic [VEC_W-1:0] acc_vec,
  input  logic             acc_level,
  input  logic             ack,
  input  logic             eoi_wr,
  input  logic             tpr_wr,
  input  logic [BUS_W-1:0] tpr_data,
  output logic             dlv_valid,
  output logic [VEC_W-1:0] dlv_vec,
  output logic [VEC_W-1:0] ppr_out,
  output logic             eoi_valid,
  output logic [VEC_W-1:0] eoi_vec,
  output logic             eoi_level
);
  logic [NVEC-1:0]  pend, svc, lvl;
  logic             pend_found, svc_found;
  logic [VEC_W-1:0] pend_top, svc_top, ppr_c, tpr_q;
  logic             offer, ack_fire, eoi_fire, strobe;
  logic             unused_tpr_hi;

  assign unused_tpr_hi = ^tpr_data[BUS_W-1:VEC_W];

  vpr_find_top #(.WIDTH(NVEC), .WORD_W(WORD_W)) u_find_pend (
    .bits(pend), .found(pend_found), .idx(pend_top));

  vpr_find_top #(.WIDTH(NVEC), .WORD_W(WORD_W)) u_find_svc (
    .bits(svc), .found(svc_found), .idx(svc_top));

  vpr_ppr #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
    .tpr(tpr_q), .svc_found(svc_found), .svc_top(svc_top), .ppr(ppr_c));

  assign offer    = glb_en && pend_found &&
                    ({pend_top[VEC_W-1:LSB], {LSB{1'b0}}} > ppr_c);
  assign ack_fire = ack && dlv_valid && glb_en;
  assign eoi_fire = eoi_wr && svc_found;
  assign strobe   = acc_valid || ack || eoi_wr || tpr_wr;

  vpr_vec_state #(.VEC_W(VEC_W)) u_state (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
    .ack_fire(ack_fire), .ack_vec(dlv_vec),
    .eoi_fire(eoi_fire), .eoi_vec(svc_top),
    .pend(pend), .svc(svc), .lvl(lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      tpr_q     <= '0;
      dlv_valid <= 1'b0;
      dlv_vec   <= '0;
      ppr_out   <= '0;
      eoi_valid <= 1'b0;
      eoi_vec   <= '0;
      eoi_level <= 1'b0;
    end else begin
      if (tpr_wr) tpr_q <= tpr_data[VEC_W-1:0];
      dlv_valid <= offer && !strobe;
      dlv_vec   <= pend_top;
      ppr_out   <= ppr_c;
      eoi_valid <= eoi_fire;
      eoi_vec   <= svc_top;
      eoi_level <= eoi_fire && lvl[svc_top];
    end
  end
endmodule

// File: rtl/vpr_checker.sv
module vpr_checker #(
  parameter int VEC_W = 8,
  localparam int LSB  = VEC_W - 4
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en,
  input logic             acc_valid,
  input logic             ack,
  input logic             eoi_wr,
  input logic             tpr_wr,
  input logic             dlv_valid,
  input logic [VEC_W-1:0] dlv_vec,
  input logic [VEC_W-1:0] ppr_out,
  input logic             eoi_valid,
  input logic             eoi_level
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ppr_out == '0 && !dlv_valid && !eoi_valid));

  p_offer_above_ppr_r5: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> ({dlv_vec[VEC_W-1:LSB], {LSB{1'b0}}} > ppr_out));

  p_offer_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_en) |-> !dlv_valid);

  p_eoi_from_write_r7: assert property (@(posedge clk) disable iff (rst)
    eoi_valid |-> $past(eoi_wr));

  p_eoi_level_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !eoi_valid |-> !eoi_level);

  p_quiet_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $past(acc_valid || ack || eoi_wr || tpr_wr) |-> !dlv_valid);
endmodule

bind vec_prio_resolver vpr_checker #(.VEC_W(VEC_W)) u_vpr_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en), .acc_valid(acc_valid), .ack(ack),
  .eoi_wr(eoi_wr), .tpr_wr(tpr_wr), .dlv_valid(dlv_valid), .dlv_vec(dlv_vec),
  .ppr_out(ppr_out), .eoi_valid(eoi_valid), .eoi_level(eoi_level));

// File: tb/vec_prio_resolver_test.sv
module vec_prio_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 256;

  logic clk = 1'b0;
  logic rst, glb_en, acc_valid, acc_level, ack, eoi_wr, tpr_wr;
  logic [7:0]  acc_vec;
  logic [31:0] tpr_data;
  logic        dlv_valid, eoi_valid, eoi_level;
  logic [7:0]  dlv_vec, ppr_out, eoi_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_prio_resolver uut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .acc_valid(acc_valid),
    .acc_vec(acc_vec), .acc_level(acc_level), .ack(ack), .eoi_wr(eoi_wr),
    .tpr_wr(tpr_wr), .tpr_data(tpr_data), .dlv_valid(dlv_valid),
    .dlv_vec(dlv_vec), .ppr_out(ppr_out), .eoi_valid(eoi_valid),
    .eoi_vec(eoi_vec), .eoi_level(eoi_level));

  // reference state
  bit [NV-1:0] m_pend, m_svc, m_lvl;
  int m_tpr, m_ppr, m_dlv_vec, m_eoi_vec;
  bit m_dlv_v, m_eoi_v, m_eoi_lvl;

  function automatic int top_of(input bit [NV-1:0] b);
    for (int i = NV-1; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  function automatic int prio_of(input int tpr, input int svc_top);
    int s;
    s = (svc_top < 0) ? 0 : svc_top;
    if ((tpr >> 4) >= (s >> 4)) return tpr;
    return s & 'hF0;
  endfunction

  task automatic model_edge();
    int ph, st, pr, ackv;
    bit offer, strobe, take;
    if (rst) begin
      m_pend = '0; m_svc = '0; m_lvl = '0; m_tpr = 0;
      m_ppr = 0; m_dlv_v = 0; m_dlv_vec = 0; m_eoi_v = 0; m_eoi_vec = 0; m_eoi_lvl = 0;
      return;
    end
    ph = top_of(m_pend);
    st = top_of(m_svc);
    pr = prio_of(m_tpr, st);
    offer  = glb_en && (ph >= 0) && ((ph & 'hF0) > pr);
    strobe = acc_valid || ack || eoi_wr || tpr_wr;
    ackv   = (ack && m_dlv_v && glb_en) ? m_dlv_vec : -1;
    take   = acc_valid && !m_pend[acc_vec];
    m_eoi_v   = eoi_wr && (st >= 0);
    m_eoi_vec = (st < 0) ? 0 : st;
    m_eoi_lvl = m_eoi_v && m_lvl[st];
    m_dlv_v   = offer && !strobe;
    m_dlv_vec = (ph < 0) ? 0 : ph;
    m_ppr     = pr;
    if (m_eoi_v) begin m_svc[st] = 0; m_lvl[st] = 0; end
    if (ackv >= 0) begin m_svc[ackv] = 1; m_pend[ackv] = 0; end
    if (take) begin m_pend[acc_vec] = 1; m_lvl[acc_vec] = acc_level; end
    if (tpr_wr) m_tpr = tpr_data & 'hFF;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5 offer valid", dlv_valid, m_dlv_v);
    if (m_dlv_v && dlv_valid) chk("R3 offered vector", dlv_vec, m_dlv_vec);
    chk("R4 priority", ppr_out, m_ppr);
    chk("R7 eoi pulse", eoi_valid, m_eoi_v);
    if (m_eoi_v && eoi_valid) begin
      chk("R7 eoi vector", eoi_vec, m_eoi_vec);
      chk("R7 eoi level", eoi_level, m_eoi_lvl);
    end else chk("R7 eoi level idle", eoi_level, 0);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic op(input bit a, input int v, input bit l, input bit k,
                    input bit e, input bit tw, input logic [31:0] td);
    acc_valid = a; acc_vec = 8'(v); acc_level = l; ack = k;
    eoi_wr = e; tpr_wr = tw; tpr_data = td;
    step();
    acc_valid = 0; ack = 0; eoi_wr = 0; tpr_wr = 0;
  endtask

  task automatic idle(); op(0, 0, 0, 0, 0, 0, 0); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R10: actual hang, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1C));
    rst = 1; glb_en = 0; acc_valid = 0; acc_vec = 0; acc_level = 0;
    ack = 0; eoi_wr = 0; tpr_wr = 0; tpr_data = 0;
    @(negedge clk);
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 dlv_valid", dlv_valid, 0);
    chk("R1 ppr", ppr_out, 0);
    chk("R1 eoi_valid", eoi_valid, 0);
    glb_en = 1;

    op(1, 'h45, 0, 0, 0, 0, 0);
    chk("R10 quiet after strobe", dlv_valid, 0);
    idle();
    chk("R3 single pending", dlv_vec, 'h45);
    op(1, 'h45, 1, 0, 0, 0, 0);       // R2 duplicate, level flag dropped
    idle();
    op(1, 'h80, 1, 0, 0, 0, 0);
    idle();
    chk("R3 highest pending", dlv_vec, 'h80);

    op(0, 0, 0, 0, 0, 1, 32'hABCD_EF90);
    idle();
    chk("R9 low byte only", ppr_out, 'h90);
    chk("R5 blocked by task priority", dlv_valid, 0);
    op(0, 0, 0, 0, 0, 1, 32'h0000_0080);
    idle();
    chk("R5 strict compare", dlv_valid, 0);
    op(0, 0, 0, 0, 0, 1, 32'h0000_007F);
    idle();
    chk("R5 class above", dlv_valid, 1);
    chk("R4 task priority", ppr_out, 'h7F);

    op(0, 0, 0, 1, 0, 0, 0);          // take 0x80
    op(0, 0, 0, 1, 0, 0, 0);          // R6 ignored: offer is low
    idle();
    chk("R4 service class wins", ppr_out, 'h80);
    op(0, 0, 0, 0, 1, 0, 0);
    chk("R7 level eoi vector", eoi_vec, 'h80);
    chk("R7 level eoi flag", eoi_level, 1);
    idle();
    chk("R7 priority recomputed", ppr_out, 'h7F);
    op(0, 0, 0, 0, 0, 1, 0);
    idle();
    chk("R6 second ack ignored", dlv_vec, 'h45);
    op(0, 0, 0, 1, 0, 0, 0);
    idle();
    chk("R4 service 0x45", ppr_out, 'h40);
    op(0, 0, 0, 0, 1, 0, 0);
    chk("R2 duplicate kept edge", eoi_level, 0);
    idle();
    op(0, 0, 0, 0, 1, 0, 0);
    chk("R8 empty eoi", eoi_valid, 0);
    idle();
    chk("R8 priority unchanged", ppr_out, 0);

    op(1, 'h90, 0, 0, 0, 0, 0);
    glb_en = 0;
    idle();
    chk("R5 disabled", dlv_valid, 0);
    op(0, 0, 0, 1, 0, 0, 0);
    glb_en = 1;
    idle();
    idle();
    chk("R6 ack ignored while disabled", dlv_vec, 'h90);
    op(0, 0, 0, 1, 0, 0, 0);
    op(0, 0, 0, 0, 1, 0, 0);
    chk("R7 edge eoi", eoi_vec, 'h90);
    idle();

    op(1, 'h0F, 0, 0, 0, 0, 0);
    idle();
    chk("R5 class zero never offered", dlv_valid, 0);
    op(1, 'h30, 1, 0, 0, 0, 0);
    idle();
    op(0, 0, 0, 1, 0, 0, 0);
    op(1, 'h60, 0, 0, 0, 0, 0);
    idle();
    chk("R4 nested priority", ppr_out, 'h30);
    chk("R5 nested offer", dlv_vec, 'h60);
    op(0, 0, 0, 1, 0, 0, 0);
    op(0, 0, 0, 0, 1, 0, 0);
    chk("R7 retires highest first", eoi_vec, 'h60);
    op(0, 0, 0, 0, 1, 0, 0);
    chk("R7 then lower", eoi_vec, 'h30);
    chk("R7 lower is level", eoi_level, 1);
    idle();

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [31:0] td;
      glb_en = (($urandom % 16) != 0);
      r = $urandom % 4;
      td = $urandom;
      if (r != 0) td[7:6] = 2'b00;
      op(($urandom % 3) == 0, $urandom % 256, $urandom % 2,
         ($urandom % 3) == 0, ($urandom % 5) == 0,
         ($urandom % 25) == 0, td);
    end
    glb_en = 1;
    idle();

    done = 1;
    summary();
    $finish;
  end
endmodule